// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block builds the byte that a flash-style memory returns on reads while an internal program or erase runs, or while the sector-erase acceptance window is still open. The command decoder tells it when an operation has been launched. That launch is the final write of the command sequence: the fourth write of a byte program, the sixth of a chip erase, or the last sector-erase write. With the launch come the operation kind and the bit 7 value being written. From then on the block raises a select so that the read multiplexer shows the status byte instead of array data.

Each status bit follows its own rule. Bit 7 polls against the written data. Bit 6 flips on every read. Bit 5 flags a timeout. Bit 4 tells which phase failed. Bit 3 shows whether the erase has left its acceptance window. Completion drops the select. A timeout holds status mode until the decoder signals a read/reset command.

Top module: `op_status_gen`

## Requirements
- R1: After reset, status_sel_o is 0 and status_o is 8'h00. Whenever status_sel_o is 0, status_o is 8'h00.
- R2: One cycle after op_start_i, status_sel_o is 1, bit 6 is 0 and bit 5 is 0, whatever the state was before.
- R3: In a program operation (op_erase_i=0 at launch), bit 7 reads as the inverse of the latched written bit 7.
- R4: In an erase operation (op_erase_i=1 at launch), bit 7 reads 0.
- R5: Bit 6 shows the current toggle state during a read strobe. It inverts once per rd_strobe_i cycle while busy_i, win_open_i or the failure flag is set. With none of the three set, a strobe leaves it unchanged.
- R6: A done_i pulse with no failure pending clears status_sel_o on the next cycle, and status_o returns to 8'h00.
- R7: timeout_i during an operation sets bit 5 on the next cycle. Bit 4 is then 0 for a program and 1 for an erase. A later done_i does not clear status mode.
- R8: Bit 3 is 1 for an erase while win_open_i is 0, and 0 while win_open_i is 1. Bit 3 is always 0 for a program.
- R9: reset_cmd_i clears the failure flag and status_sel_o on the next cycle. It takes priority over op_start_i in the same cycle.
- R10: Bits 2 to 0 read 0 in status mode.
- R11: After a timeout, bit 7 keeps its polling value and bit 6 keeps toggling on reads even with busy_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_start_i | input | 1 | Final command write accepted; an embedded operation begins |
| op_erase_i | input | 1 | Operation kind at launch: 0 program, 1 erase |
| wr_d7_i | input | 1 | Bit 7 of the data being programmed, sampled at launch |
| busy_i | input | 1 | Embedded algorithm running |
| done_i | input | 1 | Embedded algorithm completed |
| win_open_i | input | 1 | Sector-erase acceptance window open |
| timeout_i | input | 1 | Operation exceeded its time limit |
| rd_strobe_i | input | 1 | One cycle per read access |
| reset_cmd_i | input | 1 | Read/reset command sequence decoded |
| status_o | output | 8 | Status byte |
| status_sel_o | output | 1 | Show status_o instead of array data |

## Verification
On every cycle the assertions check these rules: the zero low bits, the zero byte outside status mode, the toggle inversion on an engaged read, and the clean state after a launch. They also check that bit 4 appears only with bit 5, that a completion drops the select, and that a reset command clears it. Only the bench scenarios show the bit 7 polling values for each operation kind and written bit. The same holds for the bit 3 window dependence, the ignored completion after a timeout, and the reset-over-launch priority. The bench sweeps operation kind, written bit, read count and ending.

// File: rtl/op_status_pkg.sv
package op_status_pkg;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned B_POLL  = 7;
  localparam int unsigned B_TOG   = 6;
  localparam int unsigned B_FAIL  = 5;
  localparam int unsigned B_PHASE = 4;
  localparam int unsigned B_WIN   = 3;
  localparam int unsigned RSV_W   = B_WIN;

  typedef struct packed {
    logic active;
    logic erase;
    logic d7;
    logic fail;
  } op_state_t;
endpackage

// File: rtl/ost_tracker.sv
module ost_tracker
  import op_status_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      op_start_i,
  input  logic      op_erase_i,
  input  logic      wr_d7_i,
  input  logic      done_i,
  input  logic      timeout_i,
  input  logic      reset_cmd_i,
  output op_state_t st_o
);
  op_state_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else if (reset_cmd_i) begin
      st_q.active <= 1'b0;
      st_q.fail   <= 1'b0;
    end else if (op_start_i) begin
      st_q.active <= 1'b1;
      st_q.erase  <= op_erase_i;
      st_q.d7     <= wr_d7_i;
      st_q.fail   <= 1'b0;
    end else if (st_q.active) begin
      if (timeout_i) st_q.fail <= 1'b1;
      else if (done_i && !st_q.fail) st_q.active <= 1'b0;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/ost_toggle.sv
module ost_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  input  logic rd_strobe_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tog_q <= 1'b0;
    else if (clear_i)            tog_q <= 1'b0;
    else if (en_i && rd_strobe_i) tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/ost_encode.sv
module ost_encode
  import op_status_pkg::*;
(
  input  op_state_t          st_i,
  input  logic               tog_i,
  input  logic               win_open_i,
  output logic [STAT_W-1:0]  status_o
);
  logic [STAT_W-1:0] byte_w;

  always_comb begin
    byte_w           = '0;
    byte_w[B_POLL]   = st_i.erase ? 1'b0 : ~st_i.d7;
    byte_w[B_TOG]    = tog_i;
    byte_w[B_FAIL]   = st_i.fail;
    byte_w[B_PHASE]  = st_i.fail & st_i.erase;
    byte_w[B_WIN]    = st_i.erase & ~win_open_i;
    byte_w[RSV_W-1:0] = '0;
  end

  assign status_o = st_i.active ? byte_w : '0;
endmodule

// File: rtl/op_status_gen.sv
module op_status_gen
  import op_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_start_i,
  input  logic              op_erase_i,
  input  logic              wr_d7_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              win_open_i,
  input  logic              timeout_i,
  input  logic              rd_strobe_i,
  input  logic              reset_cmd_i,
  output logic [STAT_W-1:0] status_o,
  output logic              status_sel_o
);
  op_state_t st;
  logic      tog;
  logic      tog_en;

  ost_tracker u_trk (
    .clk_i, .rst_ni, .op_start_i, .op_erase_i, .wr_d7_i,
    .done_i, .timeout_i, .reset_cmd_i, .st_o(st)
  );

  // toggling continues through the window and after a failure
  assign tog_en = st.active & (busy_i | win_open_i | st.fail);

  ost_toggle u_tog (
    .clk_i, .rst_ni,
    .clear_i(reset_cmd_i | op_start_i),
    .en_i(tog_en),
    .rd_strobe_i,
    .tog_o(tog)
  );

  ost_encode u_enc (
    .st_i(st), .tog_i(tog), .win_open_i, .status_o
  );

  assign status_sel_o = st.active;
endmodule

// File: rtl/op_status_chk.sv
module op_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       op_start_i,
  input logic       busy_i,
  input logic       done_i,
  input logic       win_open_i,
  input logic       rd_strobe_i,
  input logic       reset_cmd_i,
  input logic [7:0] status_o,
  input logic       status_sel_o
);
  assert_low_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2:0] == 3'b000);

  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_sel_o |-> status_o == 8'h00);

  assert_start_clean_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_start_i && !reset_cmd_i) |=> (status_sel_o && !status_o[6] && !status_o[5]));

  assert_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_sel_o && rd_strobe_i && !op_start_i && !reset_cmd_i && !done_i &&
     (busy_i || win_open_i || status_o[5])) |=> status_o[6] != $past(status_o[6]));

  assert_done_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_sel_o && done_i && !status_o[5] && !op_start_i && !reset_cmd_i &&
     !$past(reset_cmd_i)) |=> !status_sel_o);

  assert_phase_with_fail_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[4] |-> status_o[5]);

  assert_reset_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_cmd_i |=> (!status_sel_o && !status_o[5]));
endmodule

bind op_status_gen op_status_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_start_i(op_start_i), .busy_i(busy_i),
  .done_i(done_i), .win_open_i(win_open_i), .rd_strobe_i(rd_strobe_i),
  .reset_cmd_i(reset_cmd_i), .status_o(status_o), .status_sel_o(status_sel_o)
);

// File: tb/op_status_gen_tb.sv
`timescale 1ns/1ps
module op_status_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, op_erase = 0, wr_d7 = 0, busy = 0, done = 0;
  logic win_open = 0, timeout = 0, rd = 0, reset_cmd = 0;
  logic [7:0] status;
  logic sel;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  op_status_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_start_i(op_start), .op_erase_i(op_erase),
    .wr_d7_i(wr_d7), .busy_i(busy), .done_i(done), .win_open_i(win_open),
    .timeout_i(timeout), .rd_strobe_i(rd), .reset_cmd_i(reset_cmd),
    .status_o(status), .status_sel_o(sel)
  );

  function automatic logic [7:0] exp_byte(logic er, logic d7, logic tg, logic fl, logic wn);
    return {er ? 1'b0 : ~d7, tg, fl, fl & er, er & ~wn, 3'b000};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic launch(logic er, logic d7);
    op_erase = er; wr_d7 = d7; op_start = 1; busy = ~er; win_open = er;
    step();
    op_start = 0;
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset sel", {7'b0, sel}, 8'h01 & 8'h00);
    rst_n = 1;
    step();
    chk("R1 idle", {sel, status[6:0]}, 8'h00);

    for (int er = 0; er < 2; er++)
      for (int d7 = 0; d7 < 2; d7++)
        for (int nr = 0; nr < 4; nr++)
          for (int fl = 0; fl < 2; fl++) begin
            logic tg;
            launch(er[0], d7[0]);
            chk("R2 sel after start", {7'b0, sel}, 8'h01);
            chk(er ? "R4 R8 window open" : "R3 R10 program start", status,
                exp_byte(er[0], d7[0], 1'b0, 1'b0, win_open));
            if (er) begin
              win_open = 0; busy = 1;
              #1;
              chk("R8 window closed", status, exp_byte(1'b1, d7[0], 1'b0, 1'b0, 1'b0));
            end
            tg = 0;
            for (int i = 0; i < nr; i++) begin
              rd = 1; #1;
              chk("R5 read shows toggle", {7'b0, status[6]}, {7'b0, tg});
              step(); rd = 0; tg = ~tg;
            end
            chk("R5 after reads", status, exp_byte(er[0], d7[0], tg, 1'b0, win_open));
            if (fl) begin
              timeout = 1; step(); timeout = 0; busy = 0;
              chk("R7 timeout flags", status, exp_byte(er[0], d7[0], tg, 1'b1, 1'b0));
              rd = 1; step(); rd = 0; tg = ~tg;
              chk("R11 toggle after fail", status, exp_byte(er[0], d7[0], tg, 1'b1, 1'b0));
              done = 1; step(); done = 0;
              chk("R7 done ignored", {7'b0, sel}, 8'h01);
              reset_cmd = 1; step(); reset_cmd = 0;
              chk("R9 reset clears", {sel, status[6:0]}, 8'h00);
              chk("R9 reset status", status, 8'h00);
            end else begin
              busy = 0; done = 1; step(); done = 0;
              chk("R6 done drops sel", {7'b0, sel}, 8'h00);
              chk("R6 done status", status, 8'h00);
            end
          end

    launch(1'b0, 1'b1);
    busy = 0; win_open = 0;
    rd = 1; step(); rd = 0;
    chk("R5 no toggle when idle engine", status, exp_byte(1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    busy = 1; rd = 1; step(); rd = 0;
    chk("R5 toggle busy", {7'b0, status[6]}, 8'h01);
    launch(1'b1, 1'b0);
    chk("R2 relaunch clears toggle", status, exp_byte(1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    timeout = 1; step(); timeout = 0;
    chk("R7 erase phase", status, exp_byte(1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
    launch(1'b0, 1'b0);
    chk("R2 relaunch clears fail", status, exp_byte(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    op_start = 1; reset_cmd = 1; step(); op_start = 0; reset_cmd = 0;
    chk("R9 reset beats start", {7'b0, sel}, 8'h00);
    chk("R9 reset beats start status", status, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule